// File: doc/BRIEF.md
# Conditional Return Sequencer

This block carries out the four flag-conditional return instructions of a small 8-bit processor core. The core's fetch stage hands it a decoded opcode together with the current zero and carry flags, the stack pointer and the program counter. The program counter has already been advanced past the opcode. The block tests the condition selected by the opcode and then follows one of two paths:

- **Return taken:** it pops a two-byte return address through a byte-wide read port and produces the new program counter and a stack pointer raised by two.
- **Return not taken:** it hands back the program counter and stack pointer unchanged.

Time is counted in machine cycles of four clocks each. A taken return occupies five machine cycles and a skipped one occupies two. The last clock of the instruction is marked by a one-clock `done` pulse. While the block is busy it ignores any further start request. It also ignores a start request whose opcode is not one of the four it handles.

Top module: `cond_ret_seq`

## Requirements
- R1: Opcode 0xC0 returns exactly when the zero flag is 0, and opcode 0xC8 returns exactly when the zero flag is 1.
- R2: Opcode 0xD0 returns exactly when the carry flag is 0, and opcode 0xD8 returns exactly when the carry flag is 1.
- R3: For a taken return, `done` is high on the 20th clock of the instruction. The clock right after the accepting edge counts as the 1st clock.
- R4: For a return that is not taken, `done` is high on the 8th clock of the instruction.
- R5: A taken return strobes `mem_rd` for one clock at the 9th clock of the instruction with `mem_addr` = SP. It strobes again for one clock at the 13th clock with `mem_addr` = SP+1, wrapping modulo 0x10000. Read data is taken one clock after each strobe.
- R6: During `done` of a taken return, `pc_out` = {byte read at SP+1, byte read at SP}, and `sp_out` = SP+2 modulo 0x10000.
- R7: A return that is not taken issues no memory read. During its `done`, `pc_out` equals the accepted `pc_in` and `sp_out` equals the accepted `sp_in`.
- R8: `done` lasts exactly one clock. `busy` is high from the first clock of the instruction through the `done` clock, and low right after it.
- R9: A `start` that arrives while `busy` is high is ignored. It changes neither the timing nor the results of the instruction in progress.
- R10: A `start` with an opcode other than 0xC0, 0xC8, 0xD0 or 0xD8 is ignored: `busy` stays low and no `done` follows.
- R11: `flag_z_out` and `flag_c_out` equal the flags sampled at acceptance and hold steady for the whole instruction. No conditional return alters them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin an instruction |
| opcode | input | 8 | Decoded opcode |
| flag_z | input | 1 | Current zero flag |
| flag_c | input | 1 | Current carry flag |
| pc_in | input | 16 | Program counter already advanced past the opcode |
| sp_in | input | 16 | Stack pointer |
| mem_addr | output | 16 | Read address |
| mem_rd | output | 1 | Read strobe, one clock per byte |
| mem_rdata | input | 8 | Read data, valid one clock after the strobe |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Last clock of the instruction |
| pc_out | output | 16 | New program counter, valid with done |
| sp_out | output | 16 | New stack pointer, valid with done |
| flag_z_out | output | 1 | Zero flag carried through unchanged |
| flag_c_out | output | 1 | Carry flag carried through unchanged |

## Verification
The hardest case to reach is a second start request that lands in the middle of a taken return, at a clock where the block is already counting and its stack address is captured. A late request could restart the counter or re-sample SP. The stimulus raises `start` at a chosen clock inside the instruction, carrying a different opcode and stack pointer. The bench then checks that the read clocks, the addresses and the final `pc_out` and `sp_out` still match the first request. A separate run pops across the 0xFFFF to 0x0000 boundary to exercise the address wrap.

// File: rtl/cond_ret_pkg.sv
package cond_ret_pkg;

  // One of the four handled opcodes: pattern 110x_x000
  function automatic logic op_is_cond_ret(input logic [7:0] op);
    return (op & 8'hE7) == 8'hC0;
  endfunction

  // bit4 picks carry (1) or zero (0); bit3 gives the flag value that returns
  function automatic logic cond_holds(input logic [7:0] op, input logic z, input logic c);
    logic f;
    f = op[4] ? c : z;
    return f == op[3];
  endfunction

  function automatic logic [15:0] addr_step(input logic [15:0] a, input logic [15:0] d);
    return a + d;
  endfunction

endpackage

// File: rtl/cond_ret_decode.sv
module cond_ret_decode
  import cond_ret_pkg::*;
(
  input  logic [7:0] opcode,
  input  logic       flag_z,
  input  logic       flag_c,
  output logic       op_valid,
  output logic       cond_true
);
  always_comb begin
    op_valid  = op_is_cond_ret(opcode);
    cond_true = cond_holds(opcode, flag_z, flag_c);
  end
endmodule

// File: rtl/cond_ret_timer.sv
module cond_ret_timer #(
  parameter int MCYCLE_CLKS = 4,
  parameter int TAKEN_MC    = 5,
  parameter int SKIP_MC     = 2,
  localparam int TAKEN_LEN  = TAKEN_MC * MCYCLE_CLKS,
  localparam int SKIP_LEN   = SKIP_MC * MCYCLE_CLKS,
  localparam int CNT_W      = $clog2(TAKEN_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             taken,
  output logic [CNT_W-1:0] cnt,
  output logic             busy,
  output logic             last
);
  logic [CNT_W-1:0] end_idx;

  assign last = busy && (cnt == end_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt     <= '0;
      end_idx <= '0;
    end else if (load) begin
      busy    <= 1'b1;
      cnt     <= '0;
      end_idx <= taken ? CNT_W'(TAKEN_LEN - 1) : CNT_W'(SKIP_LEN - 1);
    end else if (last) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/cond_ret_pop.sv
module cond_ret_pop
  import cond_ret_pkg::*;
#(
  parameter int MCYCLE_CLKS = 4,
  parameter int LO_MC       = 2,
  parameter int HI_MC       = 3,
  parameter int CNT_W       = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [15:0]      sp_in,
  input  logic             active,
  input  logic [CNT_W-1:0] cnt,
  input  logic [7:0]       mem_rdata,
  output logic [15:0]      mem_addr,
  output logic             mem_rd,
  output logic [15:0]      sp_base,
  output logic [15:0]      popped
);
  localparam int LO_IDX = LO_MC * MCYCLE_CLKS;
  localparam int HI_IDX = HI_MC * MCYCLE_CLKS;

  logic       rd_lo, rd_hi, cap_lo, cap_hi;
  logic [7:0] lo_q, hi_q;

  always_comb begin
    rd_lo    = active && (cnt == CNT_W'(LO_IDX));
    rd_hi    = active && (cnt == CNT_W'(HI_IDX));
    cap_lo   = active && (cnt == CNT_W'(LO_IDX + 1));
    cap_hi   = active && (cnt == CNT_W'(HI_IDX + 1));
    mem_rd   = rd_lo || rd_hi;
    mem_addr = rd_hi ? addr_step(sp_base, 16'd1) : sp_base;
    popped   = {hi_q, lo_q};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_base <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
    end else begin
      if (load)   sp_base <= sp_in;
      if (cap_lo) lo_q    <= mem_rdata;
      if (cap_hi) hi_q    <= mem_rdata;
    end
  end
endmodule

// File: rtl/cond_ret_seq.sv
module cond_ret_seq
  import cond_ret_pkg::*;
#(
  parameter int MCYCLE_CLKS = 4,
  parameter int TAKEN_MC    = 5,
  parameter int SKIP_MC     = 2,
  parameter int LO_MC       = 2,
  parameter int HI_MC       = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [7:0]  opcode,
  input  logic        flag_z,
  input  logic        flag_c,
  input  logic [15:0] pc_in,
  input  logic [15:0] sp_in,
  output logic [15:0] mem_addr,
  output logic        mem_rd,
  input  logic [7:0]  mem_rdata,
  output logic        busy,
  output logic        done,
  output logic [15:0] pc_out,
  output logic [15:0] sp_out,
  output logic        flag_z_out,
  output logic        flag_c_out
);
  localparam int CNT_W = $clog2(TAKEN_MC * MCYCLE_CLKS + 1);

  logic             op_valid, cond_true, accept, taken_q;
  logic [CNT_W-1:0] cnt;
  logic [15:0]      pc_cap, sp_base, popped;

  assign accept = start && !busy && op_valid;

  cond_ret_decode u_dec (
    .opcode(opcode), .flag_z(flag_z), .flag_c(flag_c),
    .op_valid(op_valid), .cond_true(cond_true)
  );

  cond_ret_timer #(.MCYCLE_CLKS(MCYCLE_CLKS), .TAKEN_MC(TAKEN_MC), .SKIP_MC(SKIP_MC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(accept), .taken(cond_true),
    .cnt(cnt), .busy(busy), .last(done)
  );

  cond_ret_pop #(.MCYCLE_CLKS(MCYCLE_CLKS), .LO_MC(LO_MC), .HI_MC(HI_MC), .CNT_W(CNT_W)) u_pop (
    .clk(clk), .rst_n(rst_n), .load(accept), .sp_in(sp_in),
    .active(busy && taken_q), .cnt(cnt), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .sp_base(sp_base), .popped(popped)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      taken_q    <= 1'b0;
      pc_cap     <= '0;
      flag_z_out <= 1'b0;
      flag_c_out <= 1'b0;
    end else if (accept) begin
      taken_q    <= cond_true;
      pc_cap     <= pc_in;
      flag_z_out <= flag_z;
      flag_c_out <= flag_c;
    end
  end

  always_comb begin
    pc_out = taken_q ? popped : pc_cap;
    sp_out = taken_q ? addr_step(sp_base, 16'd2) : sp_base;
  end
endmodule

// File: rtl/cond_ret_seq_chk.sv
module cond_ret_seq_chk #(
  parameter int MCYCLE_CLKS = 4,
  parameter int TAKEN_MC    = 5,
  parameter int SKIP_MC     = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        op_valid,
  input logic        busy,
  input logic        done,
  input logic        taken,
  input logic        mem_rd,
  input logic [15:0] mem_addr,
  input logic [15:0] sp_out,
  input logic        flag_z_out,
  input logic        flag_c_out
);
  logic [15:0] cyc, first_addr;
  logic        seen_rd;

  always_ff @(posedge clk) begin
    if (!rst_n || !busy) begin
      cyc        <= '0;
      seen_rd    <= 1'b0;
      first_addr <= '0;
    end else begin
      cyc <= cyc + 16'd1;
      if (mem_rd && !seen_rd) begin
        seen_rd    <= 1'b1;
        first_addr <= mem_addr;
      end
    end
  end

  // R3
  taken_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && taken |-> cyc == 16'(TAKEN_MC * MCYCLE_CLKS - 1));
  // R4
  skip_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !taken |-> cyc == 16'(SKIP_MC * MCYCLE_CLKS - 1));
  // R5
  hi_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd && seen_rd |-> mem_addr == first_addr + 16'd1);
  // R5
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);
  // R6
  sp_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && taken |-> sp_out == first_addr + 16'd2);
  // R7
  skip_no_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !taken |-> !mem_rd);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);
  // R8
  done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  // R9
  hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> busy);
  // R10
  bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start && !op_valid |=> !busy);
  // R11
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !$rose(busy) |-> $stable(flag_z_out) && $stable(flag_c_out));
endmodule

bind cond_ret_seq cond_ret_seq_chk #(
  .MCYCLE_CLKS(MCYCLE_CLKS), .TAKEN_MC(TAKEN_MC), .SKIP_MC(SKIP_MC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .op_valid(op_valid),
  .busy(busy), .done(done), .taken(taken_q), .mem_rd(mem_rd),
  .mem_addr(mem_addr), .sp_out(sp_out),
  .flag_z_out(flag_z_out), .flag_c_out(flag_c_out)
);

// File: tb/cond_ret_seq_test.sv
module cond_ret_seq_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic        flag_z = 1'b0, flag_c = 1'b0;
  logic [15:0] pc_in = '0, sp_in = '0;
  logic [15:0] mem_addr, pc_out, sp_out;
  logic        mem_rd, busy, done, flag_z_out, flag_c_out;
  logic [7:0]  mem_rdata = 8'h00;

  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cond_ret_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
    .flag_z(flag_z), .flag_c(flag_c), .pc_in(pc_in), .sp_in(sp_in),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .pc_out(pc_out), .sp_out(sp_out),
    .flag_z_out(flag_z_out), .flag_c_out(flag_c_out)
  );

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  always @(posedge clk) if (mem_rd) mem_rdata <= mem_byte(mem_addr);

  task automatic check(input logic ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Runs one instruction; poke_at >= 0 raises a second start at that clock index
  task automatic run_ret(input logic [7:0] op, input logic z, input logic c,
                         input logic [15:0] pc, input logic [15:0] sp,
                         input logic exp_taken, input string req, input int poke_at);
    int done_at = -1, nrd = 0, rd_at0 = -1, rd_at1 = -1;
    logic [15:0] a0 = 0, a1 = 0, pco = 0, spo = 0;
    logic zo = 0, co = 0, busy0;
    int len = exp_taken ? 20 : 8;
    @(negedge clk);
    opcode = op; flag_z = z; flag_c = c; pc_in = pc; sp_in = sp; start = 1'b1;
    @(posedge clk);
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      start = (i == poke_at);
      if (i == poke_at) begin
        opcode = 8'hC8 ^ op[3:0]; flag_z = ~z; flag_c = ~c;
        pc_in = ~pc; sp_in = sp + 16'h0100;
      end
      if (i == 0) busy0 = busy;
      if (mem_rd) begin
        if (nrd == 0) begin rd_at0 = i; a0 = mem_addr; end
        else begin rd_at1 = i; a1 = mem_addr; end
        nrd++;
      end
      if (done && done_at < 0) begin
        done_at = i; pco = pc_out; spo = sp_out; zo = flag_z_out; co = flag_c_out;
      end
    end
    start = 1'b0;
    check(busy0 == 1'b1, {req, "/R8 busy"}, busy0, 1);
    check(done_at == len - 1, exp_taken ? {req, "/R3 done clock"} : {req, "/R4 done clock"}, done_at, len - 1);
    check(zo == z && co == c, {req, "/R11 flags"}, {zo, co}, {z, c});
    if (exp_taken) begin
      check(nrd == 2 && rd_at0 == 8 && rd_at1 == 12, {req, "/R5 read clocks"}, rd_at0 * 100 + rd_at1, 812);
      check(a0 == sp && a1 == sp + 16'd1, {req, "/R5 addrs"}, {a0, a1}, {sp, sp + 16'd1});
      check(pco == {mem_byte(sp + 16'd1), mem_byte(sp)}, {req, "/R6 pc"}, pco,
            {mem_byte(sp + 16'd1), mem_byte(sp)});
      check(spo == sp + 16'd2, {req, "/R6 sp"}, spo, sp + 16'd2);
    end else begin
      check(nrd == 0, {req, "/R7 no read"}, nrd, 0);
      check(pco == pc && spo == sp, {req, "/R7 pc sp"}, {pco, spo}, {pc, sp});
    end
    check(!busy && !done, {req, "/R8 idle after"}, {busy, done}, 0);
  endtask

  task automatic run_bad(input logic [7:0] op);
    int seen = 0;
    @(negedge clk);
    opcode = op; sp_in = 16'h1234; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 22; i++) begin
      if (busy || done || mem_rd) seen++;
      @(negedge clk);
    end
    check(seen == 0, "R10 bad opcode", seen, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!busy && !done && !mem_rd, "R8 reset state", {busy, done, mem_rd}, 0);
    rst_n = 1'b1;
    // R1
    run_ret(8'hC0, 1'b0, 1'b1, 16'h4001, 16'hC000, 1'b1, "R1 C0 z0", -1);
    run_ret(8'hC0, 1'b1, 1'b0, 16'h4002, 16'hC010, 1'b0, "R1 C0 z1", -1);
    run_ret(8'hC8, 1'b1, 1'b0, 16'h5000, 16'hD0FE, 1'b1, "R1 C8 z1", -1);
    run_ret(8'hC8, 1'b0, 1'b1, 16'h5001, 16'hD100, 1'b0, "R1 C8 z0", -1);
    // R2
    run_ret(8'hD0, 1'b1, 1'b0, 16'h6000, 16'h8001, 1'b1, "R2 D0 c0", -1);
    run_ret(8'hD0, 1'b0, 1'b1, 16'h6001, 16'h8002, 1'b0, "R2 D0 c1", -1);
    run_ret(8'hD8, 1'b0, 1'b1, 16'h7000, 16'h9FF0, 1'b1, "R2 D8 c1", -1);
    run_ret(8'hD8, 1'b1, 1'b0, 16'h7001, 16'h9FF2, 1'b0, "R2 D8 c0", -1);
    // R5 R6 stack wrap
    run_ret(8'hC0, 1'b0, 1'b0, 16'h0150, 16'hFFFF, 1'b1, "R6 wrap", -1);
    // R9 start during busy
    run_ret(8'hC0, 1'b0, 1'b0, 16'h2222, 16'hA000, 1'b1, "R9 poke taken", 5);
    run_ret(8'hD8, 1'b0, 1'b0, 16'h3333, 16'hB000, 1'b0, "R9 poke skip", 3);
    // R10
    run_bad(8'hC9);
    run_bad(8'hC4);
    run_bad(8'hE0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule